// File: doc/BRIEF.md
# Reset and Recovery-State Entry Controller

This block sets the architectural control state of a 64-bit core: the program counter, the next-program counter and the processor-state fields. It sets them on each kind of reset and on a trap-driven entry into the reduced-function recovery state. Each entry kind loads its own PC/nPC pair from a fixed vector base. Every entry also forces the processor-state fields to one recovery image. Between entries, an advance strobe steps the PC pair sequentially. A privileged write can replace the state fields without touching PC or nPC. When that write only raises the recovery bit, nothing else moves.

The block also handles the fatal-error handshake with the system. A detected fatal error raises a report output, and the report stays up until the system answers. The system's answer is a fatal reset, which the core treats as a soft power-on reset: the same vectors and state as a power-on. The vector base is either the virtual base or, in 43-bit physical-address mode, its physical alias. Register-file contents, the MMU and the trap table belong to other blocks.

Top module: `resetEntryCtrl`

## Requirements
- R1: While `porReq` is high at a rising clock edge, the next outputs are: `pcOut` = base|0x20, `npcOut` = base|0x24, `stateOut` = 10'h22C, `fatalReport` = 0. Every other input is ignored in that cycle.
- R2: A watchdog reset (`wdogReq`) loads `pcOut` = base|0x40 and `npcOut` = base|0x44 on the next edge.
- R3: An externally initiated reset (`extReq`) loads `pcOut` = base|0x60 and `npcOut` = base|0x64.
- R4: A software-initiated reset (`swReq`) loads `pcOut` = base|0x80 and `npcOut` = base|0x84.
- R5: A trap-driven recovery entry (`trapRecReq`) loads `pcOut` = base|0xA0 and `npcOut` = base|0xA4.
- R6: Every entry of R1 to R5 and R10 sets `stateOut` to 10'h22C. The bit layout is: [9] alternate globals = 1, [8] MMU globals = 0, [7] interrupt globals = 0, [6] interrupt enable = 0, [5] privileged = 1, [4] address mask = 0, [3] FPU enable = 1, [2] recovery = 1, [1:0] memory model = 00 (TSO).
- R7: When several entry sources assert in one cycle, only the highest-priority one takes effect. The order is: power-on, fatal reset, watchdog, external, software, trap entry. A state write or advance in that cycle is ignored.
- R8: With no entry pending, `stWrEn` loads `stWrData` into `stateOut` on the next edge and leaves `pcOut`/`npcOut` untouched apart from any advance. A write that differs from the current state only in bit 2 changes only bit 2.
- R9: `fatalDet` sets `fatalReport` on the next edge. The report then stays high until a fatal reset or power-on.
- R10: `fatalRst` acts as a soft power-on reset: `pcOut` = base|0x20, `npcOut` = base|0x24, entry state, and `fatalReport` cleared. A `fatalDet` in the same cycle is ignored.
- R11: With no entry pending, `advance` moves `npcOut` into `pcOut` and sets `npcOut` to its old value plus 4. Without `advance`, PC and nPC hold.
- R12: The base is 0xFFFF_FFFF_F000_0000 when `paMode` is 0 and 0x0000_07FF_F000_0000 when `paMode` is 1. `paMode` is sampled in the cycle of the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porReq | input | 1 | Power-on reset, synchronous, highest priority |
| fatalRst | input | 1 | Fatal reset from the system (soft power-on) |
| wdogReq | input | 1 | Watchdog reset request |
| extReq | input | 1 | Externally initiated reset request |
| swReq | input | 1 | Software-initiated reset request |
| trapRecReq | input | 1 | Trap-driven recovery-state entry request |
| stWrEn | input | 1 | Privileged write of the state fields |
| stWrData | input | 10 | State value for the privileged write |
| fatalDet | input | 1 | Fatal error detected on this core |
| advance | input | 1 | Sequential PC step strobe |
| paMode | input | 1 | Select the 43-bit physical vector base |
| pcOut | output | 64 | Program counter |
| npcOut | output | 64 | Next-program counter |
| stateOut | output | 10 | Processor-state fields |
| fatalReport | output | 1 | Fatal-error report to the system |

## Verification
The bench builds the block with its default parameters. These are the standard vector offsets, a step of 4, and physical-base support enabled. With physical-base support on, both vector bases are reachable, and each entry kind can be seen under each value of `paMode`. The 64-bit address width exposes the full upper ones of the virtual base. Random cycles pile several entry sources into one cycle, so the priority order is exercised under many combinations. Directed cases cover a write that only raises the recovery bit, and a fatal detect that lands in the same cycle as the fatal reset.

// File: rtl/rstEntryPkg.sv
package rstEntryPkg;

  localparam int STATE_W = 10;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_POR  = 3'd1,
    EV_WDOG = 3'd2,
    EV_EXT  = 3'd3,
    EV_SW   = 3'd4,
    EV_TRAP = 3'd5
  } evKind_e;

  // Field order sets bit positions: altGlobals is bit 9, memModel is bits 1:0.
  typedef struct packed {
    logic       altGlobals;
    logic       mmuGlobals;
    logic       intGlobals;
    logic       intEnable;
    logic       privileged;
    logic       addrMask;
    logic       fpuEnable;
    logic       recovery;
    logic [1:0] memModel;
  } procState_t;

  localparam procState_t ENTRY_STATE = '{
    altGlobals: 1'b1,
    mmuGlobals: 1'b0,
    intGlobals: 1'b0,
    intEnable:  1'b0,
    privileged: 1'b1,
    addrMask:   1'b0,
    fpuEnable:  1'b1,
    recovery:   1'b1,
    memModel:   2'b00
  };

  typedef struct packed {
    logic    load;
    evKind_e kind;
    logic    wrState;
    logic    adv;
  } ctlStrobe_t;

endpackage

// File: rtl/entryControl.sv
module entryControl
  import rstEntryPkg::*;
(
  input  logic       clk,
  input  logic       porReq,
  input  logic       fatalRst,
  input  logic       wdogReq,
  input  logic       extReq,
  input  logic       swReq,
  input  logic       trapRecReq,
  input  logic       stWrEn,
  input  logic       advance,
  input  logic       fatalDet,
  output ctlStrobe_t ctl,
  output logic       fatalReport
);

  logic fatalQ;

  // Priority chain: the first source that asserts picks the entry kind.
  always_comb begin
    ctl = '{load: 1'b0, kind: EV_NONE, wrState: 1'b0, adv: 1'b0};
    if (porReq) begin
      ctl.load = 1'b1;
      ctl.kind = EV_POR;
    end else if (fatalRst) begin
      ctl.load = 1'b1;
      ctl.kind = EV_POR;
    end else if (wdogReq) begin
      ctl.load = 1'b1;
      ctl.kind = EV_WDOG;
    end else if (extReq) begin
      ctl.load = 1'b1;
      ctl.kind = EV_EXT;
    end else if (swReq) begin
      ctl.load = 1'b1;
      ctl.kind = EV_SW;
    end else if (trapRecReq) begin
      ctl.load = 1'b1;
      ctl.kind = EV_TRAP;
    end else begin
      ctl.wrState = stWrEn;
      ctl.adv     = advance;
    end
  end

  // Fatal report: raised on detect, dropped only by the system's reset.
  always_ff @(posedge clk) begin
    if (porReq || fatalRst) begin
      fatalQ <= 1'b0;
    end else if (fatalDet) begin
      fatalQ <= 1'b1;
    end
  end

  assign fatalReport = fatalQ;

  AST_FATAL_HOLD: assert property (@(posedge clk) disable iff (porReq)
    (fatalReport && !fatalRst) |=> fatalReport);  // R9

  AST_FATAL_SET: assert property (@(posedge clk) disable iff (porReq)
    (fatalDet && !fatalRst) |=> fatalReport);  // R9

  AST_FATAL_CLEAR: assert property (@(posedge clk)
    (porReq || fatalRst) |=> !fatalReport);  // R10

endmodule

// File: rtl/archStateRegs.sv
module archStateRegs
  import rstEntryPkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter logic [63:0] VA_BASE    = 64'hFFFF_FFFF_F000_0000,
  parameter logic [63:0] PA_BASE    = 64'h0000_07FF_F000_0000,
  parameter bit          PA_SUPPORT = 1'b1,
  parameter int          OFF_W      = 8,
  parameter logic [OFF_W-1:0] OFF_POR  = 8'h20,
  parameter logic [OFF_W-1:0] OFF_WDOG = 8'h40,
  parameter logic [OFF_W-1:0] OFF_EXT  = 8'h60,
  parameter logic [OFF_W-1:0] OFF_SW   = 8'h80,
  parameter logic [OFF_W-1:0] OFF_TRAP = 8'hA0,
  parameter int          STEP       = 4
)(
  input  logic              clk,
  input  logic              paMode,
  input  ctlStrobe_t        ctl,
  input  logic [STATE_W-1:0] stWrData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] npcOut,
  output logic [STATE_W-1:0] stateOut
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] vecBase;
  logic [OFF_W-1:0]  offSel;
  logic [ADDR_W-1:0] vecPc;
  logic [ADDR_W-1:0] vecNpc;
  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] npcQ;
  procState_t        stQ;

  generate
    if (PA_SUPPORT) begin : g_paBase
      assign vecBase = paMode ? PA_BASE[ADDR_W-1:0] : VA_BASE[ADDR_W-1:0];
    end else begin : g_vaBase
      logic unusedPa;
      assign unusedPa = paMode;
      assign vecBase  = VA_BASE[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    case (ctl.kind)
      EV_POR:  offSel = OFF_POR;
      EV_WDOG: offSel = OFF_WDOG;
      EV_EXT:  offSel = OFF_EXT;
      EV_SW:   offSel = OFF_SW;
      EV_TRAP: offSel = OFF_TRAP;
      default: offSel = '0;
    endcase
  end

  assign vecPc  = vecBase | ADDR_W'(offSel);
  assign vecNpc = vecBase | (ADDR_W'(offSel) + STEP_V);

  always_ff @(posedge clk) begin
    if (ctl.load) begin
      pcQ  <= vecPc;
      npcQ <= vecNpc;
      stQ  <= ENTRY_STATE;
    end else begin
      if (ctl.adv) begin
        pcQ  <= npcQ;
        npcQ <= npcQ + STEP_V;
      end
      if (ctl.wrState) begin
        stQ <= procState_t'(stWrData);
      end
    end
  end

  assign pcOut    = pcQ;
  assign npcOut   = npcQ;
  assign stateOut = stQ;

  AST_LOAD_PAIR: assert property (@(posedge clk)
    ctl.load |=> (npcOut == (pcOut + STEP_V)));  // R2

  AST_HOLD_IDLE: assert property (@(posedge clk)
    (!ctl.load && !ctl.adv) |=> ($stable(pcOut) && $stable(npcOut)));  // R11

endmodule

// File: rtl/resetEntryCtrl.sv
module resetEntryCtrl
  import rstEntryPkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter logic [63:0] VA_BASE    = 64'hFFFF_FFFF_F000_0000,
  parameter logic [63:0] PA_BASE    = 64'h0000_07FF_F000_0000,
  parameter bit          PA_SUPPORT = 1'b1,
  parameter int          STEP       = 4
)(
  input  logic                clk,
  input  logic                porReq,
  input  logic                fatalRst,
  input  logic                wdogReq,
  input  logic                extReq,
  input  logic                swReq,
  input  logic                trapRecReq,
  input  logic                stWrEn,
  input  logic [STATE_W-1:0]  stWrData,
  input  logic                fatalDet,
  input  logic                advance,
  input  logic                paMode,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [ADDR_W-1:0]   npcOut,
  output logic [STATE_W-1:0]  stateOut,
  output logic                fatalReport
);

  localparam int OFF_W = 8;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  ctlStrobe_t ctl;

  entryControl u_ctl (
    .clk        (clk),
    .porReq     (porReq),
    .fatalRst   (fatalRst),
    .wdogReq    (wdogReq),
    .extReq     (extReq),
    .swReq      (swReq),
    .trapRecReq (trapRecReq),
    .stWrEn     (stWrEn),
    .advance    (advance),
    .fatalDet   (fatalDet),
    .ctl        (ctl),
    .fatalReport(fatalReport)
  );

  archStateRegs #(
    .ADDR_W    (ADDR_W),
    .VA_BASE   (VA_BASE),
    .PA_BASE   (PA_BASE),
    .PA_SUPPORT(PA_SUPPORT),
    .OFF_W     (OFF_W),
    .STEP      (STEP)
  ) u_dp (
    .clk     (clk),
    .paMode  (paMode),
    .ctl     (ctl),
    .stWrData(stWrData),
    .pcOut   (pcOut),
    .npcOut  (npcOut),
    .stateOut(stateOut)
  );

  // Checks on the block edge, built from the raw inputs.
  logic anyEntry;
  assign anyEntry = porReq | fatalRst | wdogReq | extReq | swReq | trapRecReq;

  function automatic logic [ADDR_W-1:0] baseOf(input logic pa);
    if (PA_SUPPORT && pa) return PA_BASE[ADDR_W-1:0];
    return VA_BASE[ADDR_W-1:0];
  endfunction

  AST_POR_VECTOR: assert property (@(posedge clk)
    porReq |=> (pcOut == (baseOf($past(paMode)) | ADDR_W'(8'h20))));  // R1

  AST_WDOG_VECTOR: assert property (@(posedge clk) disable iff (porReq)
    (wdogReq && !fatalRst) |=> (pcOut == (baseOf($past(paMode)) | ADDR_W'(8'h40))));  // R2

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (porReq)
    (trapRecReq && !fatalRst && !wdogReq && !extReq && !swReq)
    |=> (pcOut == (baseOf($past(paMode)) | ADDR_W'(8'hA0))));  // R5

  AST_ENTRY_STATE: assert property (@(posedge clk)
    anyEntry |=> (stateOut == STATE_W'(ENTRY_STATE)));  // R6

  AST_WRITE_KEEPS_PC: assert property (@(posedge clk) disable iff (porReq)
    (stWrEn && !anyEntry && !advance) |=> ($stable(pcOut) && $stable(npcOut)));  // R8

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (porReq)
    (stWrEn && !anyEntry) |=> (stateOut == $past(stWrData)));  // R8

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (porReq)
    (advance && !anyEntry)
    |=> ((pcOut == $past(npcOut)) && (npcOut == $past(npcOut) + STEP_V)));  // R11

endmodule

// File: tb/resetEntryCtrl_bench.sv
module resetEntryCtrl_bench;

  localparam logic [63:0] VA_B = 64'hFFFF_FFFF_F000_0000;
  localparam logic [63:0] PA_B = 64'h0000_07FF_F000_0000;
  localparam logic [9:0]  ENTRY = 10'h22C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic porReq = 1'b1, fatalRst = 1'b0, wdogReq = 1'b0, extReq = 1'b0;
  logic swReq = 1'b0, trapRecReq = 1'b0, stWrEn = 1'b0, fatalDet = 1'b0;
  logic advance = 1'b0, paMode = 1'b0;
  logic [9:0]  stWrData = '0;
  logic [63:0] pcOut, npcOut;
  logic [9:0]  stateOut;
  logic        fatalReport;

  resetEntryCtrl u_resetEntryCtrl (
    .clk(clk), .porReq(porReq), .fatalRst(fatalRst), .wdogReq(wdogReq),
    .extReq(extReq), .swReq(swReq), .trapRecReq(trapRecReq),
    .stWrEn(stWrEn), .stWrData(stWrData), .fatalDet(fatalDet),
    .advance(advance), .paMode(paMode), .pcOut(pcOut), .npcOut(npcOut),
    .stateOut(stateOut), .fatalReport(fatalReport)
  );

  int total = 0;
  int bad = 0;
  logic [63:0] mPc, mNpc;
  logic [9:0]  mSt;
  logic        mFat;
  bit          mValid = 1'b0;
  string       tag = "R1";

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] baseOf(input logic pa);
    return pa ? PA_B : VA_B;
  endfunction

  task automatic checkAll();
    if (mValid) begin
      chk(pcOut === mPc, tag, pcOut, mPc);
      chk(npcOut === mNpc, tag, npcOut, mNpc);
      chk(stateOut === mSt, (tag == "R8") ? "R8" : "R6", 64'(stateOut), 64'(mSt));
      chk(fatalReport === mFat, (tag == "R10" || tag == "R1") ? tag : "R9",
          64'(fatalReport), 64'(mFat));
    end
  endtask

  // Next-state prediction from the requirements.
  task automatic predict();
    int n;
    logic [63:0] b;
    n = int'(porReq) + int'(fatalRst) + int'(wdogReq) + int'(extReq)
      + int'(swReq) + int'(trapRecReq);
    b = baseOf(paMode);
    if (porReq) begin
      mPc = b | 64'h20; mNpc = b | 64'h24; mSt = ENTRY; mFat = 1'b0;
      mValid = 1'b1; tag = "R1";
    end else if (fatalRst) begin
      mPc = b | 64'h20; mNpc = b | 64'h24; mSt = ENTRY; mFat = 1'b0; tag = "R10";
    end else begin
      if (fatalDet) mFat = 1'b1;
      if (wdogReq) begin
        mPc = b | 64'h40; mNpc = b | 64'h44; mSt = ENTRY; tag = "R2";
      end else if (extReq) begin
        mPc = b | 64'h60; mNpc = b | 64'h64; mSt = ENTRY; tag = "R3";
      end else if (swReq) begin
        mPc = b | 64'h80; mNpc = b | 64'h84; mSt = ENTRY; tag = "R4";
      end else if (trapRecReq) begin
        mPc = b | 64'hA0; mNpc = b | 64'hA4; mSt = ENTRY; tag = "R5";
      end else begin
        tag = stWrEn ? "R8" : "R11";
        if (stWrEn) mSt = stWrData;
        if (advance) begin
          mPc = mNpc; mNpc = mNpc + 64'd4;
        end
      end
    end
    if (n > 1) tag = "R7";
    else if (n == 1 && paMode) tag = "R12";
  endtask

  task automatic drive(input bit por, input bit fr, input bit wd, input bit ex,
                       input bit sw, input bit tr, input bit we,
                       input logic [9:0] wdat, input bit fd, input bit adv,
                       input bit pa);
    @(negedge clk);
    checkAll();
    porReq = por; fatalRst = fr; wdogReq = wd; extReq = ex; swReq = sw;
    trapRecReq = tr; stWrEn = we; stWrData = wdat; fatalDet = fd;
    advance = adv; paMode = pa;
    predict();
  endtask

  task automatic idle(input bit adv);
    drive(0, 0, 0, 0, 0, 0, 0, '0, 0, adv, 0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: power-on reset, virtual base
    drive(1, 0, 0, 0, 0, 0, 0, '0, 0, 1, 0);
    drive(1, 0, 0, 0, 0, 0, 1, 10'h3FF, 1, 1, 0);
    idle(1);
    idle(1);
    idle(0);   // R11 hold
    // R2..R5 on each base (R12)
    for (int p = 0; p < 2; p++) begin
      drive(0, 0, 1, 0, 0, 0, 0, '0, 0, 0, p[0]); idle(1);
      drive(0, 0, 0, 1, 0, 0, 0, '0, 0, 0, p[0]); idle(1);
      drive(0, 0, 0, 0, 1, 0, 0, '0, 0, 0, p[0]); idle(1);
      drive(0, 0, 0, 0, 0, 1, 0, '0, 0, 0, p[0]); idle(1);
      drive(1, 0, 0, 0, 0, 0, 0, '0, 0, 0, p[0]); idle(1);
    end
    // R7: everything at once below power-on, then lower combinations
    drive(0, 1, 1, 1, 1, 1, 1, 10'h155, 0, 1, 0); idle(0);
    drive(0, 0, 0, 1, 1, 1, 1, 10'h155, 0, 1, 1); idle(0);
    drive(0, 0, 0, 0, 1, 1, 0, '0, 0, 1, 0); idle(0);
    // R8: clear recovery, then set only it back
    drive(0, 0, 0, 0, 0, 0, 1, ENTRY & ~10'h004, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1, ENTRY, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 10'h0F3, 0, 1, 0);
    idle(0);
    // R9/R10: detect, hold, then fatal reset with a fresh detect alongside
    drive(0, 0, 0, 0, 0, 0, 0, '0, 1, 1, 0);
    idle(1); idle(1);
    drive(0, 0, 1, 0, 0, 0, 0, '0, 0, 0, 0);
    idle(1);
    drive(0, 1, 0, 0, 0, 0, 0, '0, 1, 1, 1);
    idle(1);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 97) == 0, ($urandom % 41) == 0, ($urandom % 23) == 0,
            ($urandom % 23) == 0, ($urandom % 23) == 0, ($urandom % 19) == 0,
            ($urandom % 9) == 0, 10'($urandom), ($urandom % 31) == 0,
            ($urandom % 2) == 0, ($urandom % 2) == 0);
    end
    idle(0);
    @(negedge clk);
    checkAll();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule